// File: doc/BRIEF.md
# Reversible One-Hot Address Decoder

This block turns an N-bit binary address into a 2^N-wide one-hot select word. Its network uses only reversible gates. A single four-input, four-output gate decodes the two low address bits into four lines. That gate's two spare inputs are tied to the constants 0 and 1. Each higher address bit adds one stage of three-input controlled-swap gates, one gate per line already present, and each stage doubles the number of lines. The address bit of a stage passes from gate to gate as the control signal, and it leaves the last gate of the stage as a garbage line.

A decoder of N bits uses 2^N - 3 gates and produces N - 2 garbage lines. The one-hot word and the garbage lines are captured in output registers. Results therefore appear one clock after the address is presented. Every gate carries a check that its output can be traced back to exactly one input pattern.

Top module: `rev_decoder`

## Requirements
- R1: A synchronous active-high reset clears `dec_q` and `garb_q` to all zeros at the clock edge where `rst` is sampled high.
- R2: At each clock edge where `rst` is low, `dec_q` loads a word with exactly one bit set. The set bit sits at index equal to the unsigned value of `addr` at that edge, so bit i means address i.
- R3: The two low address bits are decoded by a four-input gate. Its inputs are A = `addr[0]` and B = `addr[1]`, with C fixed at 0 and D fixed at 1. Its outputs P, Q, R and S drive lines 1, 2, 3 and 0. For N = 2, the codes 0 to 3 select bits 0 to 3.
- R4: Each stage that handles address bit k keeps every active line in the lower half (below 2^k) when bit k is 0. When bit k is 1, it moves the active line up by 2^k. Each stage also preserves the number of active lines.
- R5: `garb_q` bit j loads `addr[j+2]` at the same edge as `dec_q`, giving N - 2 garbage lines. When N = 2, `garb_q` is a single bit that is always 0.
- R6: Every gate in the network is a bijection. Its outputs match exactly one input pattern, and that pattern is the one applied.
- R7: R2 to R5 hold for every N from 2 to 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | N | Binary address |
| dec_q | output | 2^N | Registered one-hot select word |
| garb_q | output | max(N-2,1) | Registered garbage lines, one per stage |

## Verification
A wrong internal line shows up at the ports one clock after the address that exercises it. It appears either as a select word with zero or two bits set, or as the single bit landing in the wrong half of the word. Because each stage owns one address bit, a fault in stage k shows only for addresses with a particular value of bit k. An exhaustive sweep of every address therefore exposes it, at the latest, after 2^N cycles. A garbage line that fails to track its address bit is visible on `garb_q` in that same cycle.

// File: rtl/rdec_pkg.sv
package rdec_pkg;

  // Four-input gate. Input packed as {A,B,C,D}, output as {P,Q,R,S}.
  function automatic logic [3:0] hl_map(input logic [3:0] v);
    logic a, b, c, d, p, q, r, s;
    {a, b, c, d} = v;
    p = (a & ~b) ^ (~b & c) ^ (b & ~d);
    q = (a & b) ^ (~b & c) ^ (b & d);
    r = (~a & b) ^ (~b & c) ^ (b & d);
    s = (a & ~b) ^ (b & c) ^ (~b & d);
    return {p, q, r, s};
  endfunction

  // Number of input patterns that produce y.
  function automatic int hl_hits(input logic [3:0] y);
    int n;
    n = 0;
    for (int i = 0; i < 16; i++)
      if (hl_map(4'(i)) == y) n++;
    return n;
  endfunction

  // Input pattern that produces y (search over all inputs).
  function automatic logic [3:0] hl_undo(input logic [3:0] y);
    logic [3:0] x;
    x = '0;
    for (int i = 0; i < 16; i++)
      if (hl_map(4'(i)) == y) x = 4'(i);
    return x;
  endfunction

  // Controlled swap. Input {A,B,C}, output {A, A'B^AC, A'C^AB}.
  function automatic logic [2:0] fr_map(input logic [2:0] v);
    logic a, b, c;
    {a, b, c} = v;
    return {a, (~a & b) ^ (a & c), (~a & c) ^ (a & b)};
  endfunction

  function automatic int fr_hits(input logic [2:0] y);
    int n;
    n = 0;
    for (int i = 0; i < 8; i++)
      if (fr_map(3'(i)) == y) n++;
    return n;
  endfunction

  function automatic logic [2:0] fr_undo(input logic [2:0] y);
    logic [2:0] x;
    x = '0;
    for (int i = 0; i < 8; i++)
      if (fr_map(3'(i)) == y) x = 3'(i);
    return x;
  endfunction

endpackage

// File: rtl/rdec_hl_gate.sv
module rdec_hl_gate
  import rdec_pkg::*;
(
  input  logic [3:0] abcd,
  output logic [3:0] pqrs
);

  assign pqrs = hl_map(abcd);

  always_comb begin
    if (!$isunknown(abcd)) begin
      // R6
      hl_bijection_chk: assert (hl_hits(pqrs) == 1 && hl_undo(pqrs) == abcd);
    end
  end

endmodule

// File: rtl/rdec_fredkin_gate.sv
module rdec_fredkin_gate
  import rdec_pkg::*;
(
  input  logic [2:0] abc,
  output logic [2:0] pqr
);

  assign pqr = fr_map(abc);

  always_comb begin
    if (!$isunknown(abc)) begin
      // R6
      fr_bijection_chk: assert (fr_hits(pqr) == 1 && fr_undo(pqr) == abc);
    end
  end

endmodule

// File: rtl/rdec_stage.sv
module rdec_stage #(
  parameter int LINES_IN = 4
) (
  input  logic                  ctrl_in,
  input  logic [LINES_IN-1:0]   lines_in,
  output logic [2*LINES_IN-1:0] lines_out,
  output logic                  ctrl_out
);

  // The address bit threads through the gates as the control signal.
  logic [LINES_IN:0] ctrl_chain;
  assign ctrl_chain[0] = ctrl_in;
  assign ctrl_out      = ctrl_chain[LINES_IN];

  for (genvar i = 0; i < LINES_IN; i++) begin : g_gate
    logic [2:0] g_out;
    rdec_fredkin_gate u_fr (
      .abc ({ctrl_chain[i], lines_in[i], 1'b0}),
      .pqr (g_out)
    );
    assign ctrl_chain[i+1]         = g_out[2];
    assign lines_out[i]            = g_out[1];
    assign lines_out[i + LINES_IN] = g_out[0];
  end

  always_comb begin
    if (!$isunknown({ctrl_in, lines_in})) begin
      // R4
      stage_count_chk: assert ($countones(lines_out) == $countones(lines_in));
    end
  end

endmodule

// File: rtl/rev_decoder.sv
module rev_decoder #(
  parameter int N = 6
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [N-1:0]                         addr,
  output logic [(1<<N)-1:0]                    dec_q,
  output logic [((N > 2) ? N - 2 : 1)-1:0]     garb_q
);

  localparam int OUT_W  = 1 << N;
  localparam int GARB_W = (N > 2) ? N - 2 : 1;
  localparam int TREE_W = (1 << (N + 1)) - 4;

  // Level s (2..N) holds 2^s lines at offset 2^s - 4.
  logic [TREE_W-1:0] tree;
  logic [GARB_W-1:0] garb_c;
  logic [3:0]        core_out;

  // Core: A = addr[0], B = addr[1], C = 0, D = 1.
  rdec_hl_gate u_core (
    .abcd ({addr[0], addr[1], 1'b0, 1'b1}),
    .pqrs (core_out)
  );

  // Line order {R,Q,P,S} -> lines 3..0.
  assign tree[3:0] = {core_out[1], core_out[2], core_out[3], core_out[0]};

  for (genvar s = 2; s < N; s++) begin : g_stage
    rdec_stage #(.LINES_IN(1 << s)) u_st (
      .ctrl_in   (addr[s]),
      .lines_in  (tree[(1 << s) - 4 +: (1 << s)]),
      .lines_out (tree[(1 << (s + 1)) - 4 +: (1 << (s + 1))]),
      .ctrl_out  (garb_c[s-2])
    );
  end

  if (N == 2) begin : g_no_garb
    assign garb_c = 1'b0;
  end

  always_comb begin
    if (!$isunknown(addr[1:0])) begin
      // R3
      core_onehot_chk: assert ($countones(core_out) == 1);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec_q  <= '0;
      garb_q <= '0;
    end else begin
      dec_q  <= tree[TREE_W - OUT_W +: OUT_W];
      garb_q <= garb_c;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (dec_q == '0 && garb_q == '0));

  // R2
  onehot_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $countones(dec_q) == 1);

  // R2
  position_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> dec_q == ({{(OUT_W-1){1'b0}}, 1'b1} << $past(addr)));

  if (N > 2) begin : g_garb_chk
    // R5
    garbage_chk: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> garb_q == $past(addr[N-1:2]));
  end

endmodule

// File: tb/sim_rev_decoder.sv
`timescale 1ns/1ps
module sim_rev_decoder;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst;
  logic [5:0] addr;

  logic [63:0] d6; logic [3:0] g6;
  logic [31:0] d5; logic [2:0] g5;
  logic [15:0] d4; logic [1:0] g4;
  logic [7:0]  d3; logic [0:0] g3;
  logic [3:0]  d2; logic [0:0] g2;

  rev_decoder #(.N(6)) u0   (.clk(clk), .rst(rst), .addr(addr),      .dec_q(d6), .garb_q(g6));
  rev_decoder #(.N(5)) u_n5 (.clk(clk), .rst(rst), .addr(addr[4:0]), .dec_q(d5), .garb_q(g5));
  rev_decoder #(.N(4)) u_n4 (.clk(clk), .rst(rst), .addr(addr[3:0]), .dec_q(d4), .garb_q(g4));
  rev_decoder #(.N(3)) u_n3 (.clk(clk), .rst(rst), .addr(addr[2:0]), .dec_q(d3), .garb_q(g3));
  rev_decoder #(.N(2)) u_n2 (.clk(clk), .rst(rst), .addr(addr[1:0]), .dec_q(d2), .garb_q(g2));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [63:0] seen = '0;
  int pend_a[$];
  bit pend_r[$];

  task automatic chk(input string tag, input int w, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s N=%0d actual=%h expected=%h", tag, w, act, exp);
    end
  endtask

  // Reference: a bit per address, garbage is the address above bit 1.
  task automatic compare(input bit r, input int a);
    for (int w = 2; w <= 6; w++) begin
      int am;
      logic [63:0] ed, eg, ad, ag;
      string td;
      am = a % (1 << w);
      ed = r ? 64'd0 : (64'd1 << am);
      eg = (r || w == 2) ? 64'd0 : 64'(am >> 2);
      case (w)
        6: begin ad = d6; ag = 64'(g6); end
        5: begin ad = 64'(d5); ag = 64'(g5); end
        4: begin ad = 64'(d4); ag = 64'(g4); end
        3: begin ad = 64'(d3); ag = 64'(g3); end
        default: begin ad = 64'(d2); ag = 64'(g2); end
      endcase
      if (r)                  td = "R1";
      else if (w == 2)        td = "R3";
      else if (w == 6 && am >= 32) td = "R4";
      else if (w == 6)        td = "R2";
      else                    td = "R7";
      chk(td, w, ad, ed);
      chk(r ? "R1" : "R5", w, ag, eg);
      if (w == 6 && !r) seen = seen | d6;
    end
  endtask

  task automatic cycle(input bit r, input int a);
    rst  = r;
    addr = 6'(a);
    pend_r.push_back(r);
    pend_a.push_back(a);
    @(posedge clk);
    @(negedge clk);
    compare(pend_r.pop_front(), pend_a.pop_front());
  endtask

  initial begin
    logic [7:0] lf;
    rst  = 1'b1;
    addr = 6'd5;
    @(negedge clk);
    cycle(1, 5);
    cycle(1, 42);
    // Full ascending sweep: R2, R3, R4, R7
    for (int i = 0; i < 64; i++) cycle(0, i);
    // R6: every address reached a distinct output bit
    chk("R6", 6, seen, {64{1'b1}});
    // Descending sweep
    for (int i = 63; i >= 0; i--) cycle(0, i);
    // Pseudo-random pattern
    lf = 8'hA5;
    for (int i = 0; i < 40; i++) begin
      cycle(0, int'(lf[5:0]));
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
    end
    // Halves alternating: top bit toggles every cycle (R4)
    for (int i = 0; i < 8; i++) begin
      cycle(0, 0);
      cycle(0, 63);
      cycle(0, 31);
      cycle(0, 32);
    end
    // Reset in mid-run (R1), then resume
    cycle(1, 37);
    cycle(0, 37);
    cycle(0, 12);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule